// File: doc/BRIEF.md
# Trimmed Square-Wave Generator

This block turns a steady reference strobe into a square wave on one output pin. There are four rate settings. Two are low-rate outputs: a slow one and a middle one, each made by a divider. Two settings pass the reference straight through as a fast square wave, so the pin toggles on every strobe. A signed trim value corrects the two divided rates in parts-per-million steps. The fast rate is never corrected.

The correction works on the reference strobes rather than on the oscillator. An accumulator spreads the requested number of corrections evenly over a correction window of `CORR_PERIOD` strobes. A positive trim makes the divider count two on some strobes, which adds counts. A negative trim makes the divider ignore some strobes, which drops counts. Clearing the enable, or changing the rate setting, restarts the divider and the trim phase. The output then starts again from low with a full first half-period. This means no shortened (runt) pulse appears on the pin.

Top module: `sqw_trim_gen`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises, `sq_out` is low.
- R2: With `rate_sel` equal to 2 or 3, `sq_out` inverts on every accepted `ref_tick`, and `trim` has no effect.
- R3: With `rate_sel` equal to 0, `sq_out` inverts each time the corrected count crosses a multiple of `HALF_SLOW`. The output level equals floor(C / `HALF_SLOW`) mod 2, where C is the corrected count since restart.
- R4: With `rate_sel` equal to 1, the same rule as R3 applies, using `HALF_MID`.
- R5: A positive `trim` value T adds exactly floor(n·T / `CORR_PERIOD`) extra counts after n accepted ticks. The corrected count is then C = n + floor(n·T / `CORR_PERIOD`).
- R6: A negative `trim` value −M drops exactly floor(n·M / `CORR_PERIOD`) ticks. The corrected count is then C = n − floor(n·M / `CORR_PERIOD`).
- R7: A `trim` value of −128 (8'h80) is treated as −127, so the correction never exceeds 127 steps per window.
- R8: When `wave_en` is low at a clock edge, `sq_out` is low after that edge. The divider count and the trim phase restart from zero, and a `ref_tick` in that cycle is not counted.
- R9: A clock edge at which `rate_sel` differs from its value at the previous edge is a restart. At that edge `sq_out` goes low, the counts clear, and that cycle's `ref_tick` is dropped.
- R10: With `trim` equal to 0, the corrected count equals the number of accepted ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle strobe at the reference rate (twice the fast output rate) |
| wave_en | input | 1 | Square-wave enable; low holds the output low and restarts the counts |
| rate_sel | input | 2 | 0 slow corrected, 1 middle corrected, 2 and 3 fast uncorrected |
| trim | input | 8 | Signed two's-complement ppm trim |
| sq_out | output | 1 | Square-wave output |

## Verification
The bench aims at the extreme trims, ±127 and −128. A design that inverted the sign, or took −128 at full magnitude, would drift from the expected edge positions within a few windows. It also changes `rate_sel` with the output enabled. A divider that was not restarted then would leave a stale partial count, and the first half-period would be too short. The short half-periods used by the bench put inserted counts right on a terminal count. A divider that handled a two-count step badly would skip or double an edge there. The fast settings are run with a nonzero trim, which catches any correction that leaks into the uncompensated path.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

   typedef enum logic [1:0] {
      RATE_SLOW   = 2'd0,
      RATE_MID    = 2'd1,
      RATE_FAST_A = 2'd2,
      RATE_FAST_B = 2'd3
   } rate_e;

   function automatic logic rate_is_fast(input logic [1:0] sel);
      return (sel == RATE_FAST_A) || (sel == RATE_FAST_B);
   endfunction

   typedef struct packed {
      logic ins;
      logic drop;
   } corr_t;

endpackage

// File: rtl/sqw_trim_accum.sv
module sqw_trim_accum
   import sqw_pkg::*;
#(
   parameter int TRIM_W      = 8,
   parameter int CORR_PERIOD = 1_000_000,
   parameter bit SAT_MIN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              tick_i,
   input  logic [TRIM_W-1:0] trim_i,
   output corr_t             corr_o
);
   localparam int ACC_W = $clog2(CORR_PERIOD) + 2;
   localparam int MAG_W = TRIM_W;

   logic [MAG_W-1:0] mag;
   logic [ACC_W-1:0] acc_q, acc_sum;
   logic             neg, hit;

   assign neg = trim_i[TRIM_W-1];

   generate
      if (SAT_MIN) begin : g_sat
         always_comb begin
            if (trim_i == {1'b1, {(TRIM_W-1){1'b0}}})
               mag = {1'b0, {(TRIM_W-1){1'b1}}};
            else if (neg)
               mag = MAG_W'(~trim_i + 1'b1);
            else
               mag = trim_i;
         end
      end else begin : g_wrap
         always_comb mag = neg ? MAG_W'(~trim_i + 1'b1) : trim_i;
      end
   endgenerate

   assign acc_sum = acc_q + ACC_W'(mag);
   assign hit     = (acc_sum >= ACC_W'(CORR_PERIOD));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= '0;
      else if (clr_i)
         acc_q <= '0;
      else if (tick_i)
         acc_q <= hit ? (acc_sum - ACC_W'(CORR_PERIOD)) : acc_sum;
   end

   always_comb begin
      corr_o.ins  = tick_i && hit && !neg;
      corr_o.drop = tick_i && hit && neg;
   end

   // R5
   acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q < ACC_W'(CORR_PERIOD));

   // R10
   zero_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trim_i == '0) |-> !(corr_o.ins || corr_o.drop));

   // R6
   corr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(corr_o.ins && corr_o.drop));

endmodule

// File: rtl/sqw_comp_div.sv
module sqw_comp_div
   import sqw_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             tick_i,
   input  corr_t            corr_i,
   input  logic [CNT_W-1:0] half_i,
   output logic             wave_o
);
   logic [CNT_W-1:0] cnt_q, step, sum;
   logic             wrap;

   always_comb begin
      if (!tick_i || corr_i.drop) step = '0;
      else if (corr_i.ins)        step = CNT_W'(2);
      else                        step = CNT_W'(1);
   end

   assign sum  = cnt_q + step;
   assign wrap = (sum >= half_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         wave_o <= 1'b0;
      end else if (clr_i) begin
         cnt_q  <= '0;
         wave_o <= 1'b0;
      end else if (wrap) begin
         cnt_q  <= sum - half_i;
         wave_o <= ~wave_o;
      end else begin
         cnt_q  <= sum;
      end
   end

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
      cnt_q < half_i);

   // R6
   drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && corr_i.drop && !clr_i) |=> $stable(cnt_q) && $stable(wave_o));

endmodule

// File: rtl/sqw_trim_gen.sv
module sqw_trim_gen
   import sqw_pkg::*;
#(
   parameter int TRIM_W      = 8,
   parameter int HALF_SLOW   = 4096,
   parameter int HALF_MID    = 8,
   parameter int CORR_PERIOD = 1_000_000,
   parameter bit SAT_MIN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              wave_en,
   input  logic [1:0]        rate_sel,
   input  logic [TRIM_W-1:0] trim,
   output logic              sq_out
);
   localparam int HALF_MAX = (HALF_SLOW > HALF_MID) ? HALF_SLOW : HALF_MID;
   localparam int CNT_W    = $clog2(HALF_MAX + 2) + 1;

   generate
      if (HALF_SLOW < 2 || HALF_MID < 2) begin : g_bad_half
         $error("half periods must be at least 2");
      end
      if (CORR_PERIOD <= (1 << (TRIM_W - 1))) begin : g_bad_period
         $error("CORR_PERIOD must exceed the largest trim magnitude");
      end
   endgenerate

   logic [1:0]       sel_q;
   logic             restart, acc_tick, fast_q, slow_wave;
   corr_t            corr;
   logic [CNT_W-1:0] half;

   assign restart  = !wave_en || (rate_sel != sel_q);
   assign acc_tick = ref_tick && !restart;
   assign half     = (rate_sel == RATE_SLOW) ? CNT_W'(HALF_SLOW) : CNT_W'(HALF_MID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= RATE_SLOW;
         fast_q <= 1'b0;
      end else begin
         sel_q <= rate_sel;
         if (restart)       fast_q <= 1'b0;
         else if (ref_tick) fast_q <= ~fast_q;
      end
   end

   sqw_trim_accum #(
      .TRIM_W      (TRIM_W),
      .CORR_PERIOD (CORR_PERIOD),
      .SAT_MIN     (SAT_MIN)
   ) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (restart),
      .tick_i (acc_tick),
      .trim_i (trim),
      .corr_o (corr)
   );

   sqw_comp_div #(
      .CNT_W (CNT_W)
   ) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (restart),
      .tick_i (acc_tick),
      .corr_i (corr),
      .half_i (half),
      .wave_o (slow_wave)
   );

   assign sq_out = rate_is_fast(sel_q) ? fast_q : slow_wave;

   // R8
   dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wave_en |=> !sq_out);

   // R9
   sel_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_en && rate_sel != sel_q) |=> !sq_out);

   // R2
   fast_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_en && rate_sel == sel_q && rate_is_fast(rate_sel) && ref_tick)
         |=> (sq_out != $past(sq_out)));

   // R3
   edge_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_out != $past(sq_out)) |-> $past(ref_tick || restart));

endmodule

// File: tb/sqw_trim_gen_bench.sv
module sqw_trim_gen_bench;
   localparam int HS = 40;
   localparam int HM = 6;
   localparam int CP = 300;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b0;
   logic       wave_en = 1'b0;
   logic [1:0] rate_sel = 2'd0;
   logic [7:0] trim = 8'd0;
   logic       sq_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   longint n_acc = 0;
   logic [1:0] prev_sel = 2'd0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   sqw_trim_gen #(
      .HALF_SLOW   (HS),
      .HALF_MID    (HM),
      .CORR_PERIOD (CP)
   ) u_sqw_trim_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_tick (ref_tick),
      .wave_en  (wave_en),
      .rate_sel (rate_sel),
      .trim     (trim),
      .sq_out   (sq_out)
   );

   function automatic longint trim_mag(input logic [7:0] t);
      if (t == 8'h80) return 127;   // R7 clamp
      if (t[7]) return 256 - longint'(t);
      return longint'(t);
   endfunction

   function automatic logic exp_level(input longint n, input logic [1:0] sel,
                                      input logic [7:0] t);
      longint c, k, h;
      if (sel >= 2) return logic'(n % 2);
      k = (n * trim_mag(t)) / CP;
      c = t[7] ? (n - k) : (n + k);
      h = (sel == 2'd0) ? HS : HM;
      return logic'((c / h) % 2);
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: sq_out=%0b expected=%0b (n=%0d sel=%0d trim=%0d)",
                  req, act, exp, n_acc, rate_sel, $signed(trim));
      end
   endtask

   task automatic run(input int cycles, input int pct);
      for (int i = 0; i < cycles; i++) begin
         ref_tick = (($urandom % 100) < pct);
         @(posedge clk);
         if (!wave_en || rate_sel != prev_sel) n_acc = 0;
         else if (ref_tick) n_acc++;
         prev_sel = rate_sel;
         @(negedge clk);
         check(cur_req, sq_out, exp_level(n_acc, rate_sel, trim));
      end
      ref_tick = 1'b0;
   endtask

   task automatic segment(input string req, input logic [1:0] s,
                          input logic [7:0] t, input int cycles, input int pct);
      cur_req  = "R8";
      wave_en  = 1'b0;
      run(2, 50);
      rate_sel = s;
      trim     = t;
      run(1, 50);
      cur_req  = req;
      wave_en  = 1'b1;
      run(cycles, pct);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      check("R1", sq_out, 1'b0);
      repeat (3) @(negedge clk);
      check("R1", sq_out, 1'b0);
      rst_n = 1'b1;
      cur_req = "R1";
      run(1, 0);

      segment("R10", 2'd0, 8'd0, 400, 70);
      segment("R4",  2'd1, 8'd0, 200, 60);
      segment("R5",  2'd0, 8'd127, 700, 80);
      segment("R5",  2'd1, 8'd127, 300, 90);
      segment("R6",  2'd0, 8'h81, 700, 80);
      segment("R6",  2'd1, 8'h81, 300, 90);
      segment("R7",  2'd0, 8'h80, 700, 80);
      segment("R7",  2'd1, 8'h80, 400, 100);
      segment("R2",  2'd2, 8'd100, 150, 50);
      segment("R2",  2'd3, 8'h90, 150, 50);
      segment("R3",  2'd0, 8'd37, 500, 100);

      // R9: change rate with the output enabled, ticks during the change
      cur_req = "R9";
      rate_sel = 2'd1; run(1, 100);
      run(40, 100);
      rate_sel = 2'd2; run(1, 100);
      run(20, 70);
      rate_sel = 2'd0; run(1, 100);
      run(200, 70);

      // R8: disable in the middle of a run, then resume from zero
      cur_req = "R8";
      wave_en = 1'b0; run(3, 100);
      wave_en = 1'b1; run(120, 100);

      for (int j = 0; j < 8; j++) begin
         segment("R3", 2'($urandom % 4), 8'($urandom), 300, 30 + ($urandom % 70));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule